// File: doc/BRIEF.md
# Masked Cache-Line Gather Engine

This block carries out a vector gather for a 16-lane SIMD datapath with 32-bit elements. A gather starts with a scalar base address, one offset per lane and a write mask. A set mask bit marks a lane that still has to be loaded. For each pending lane, the element address is the base plus four times that lane's offset.

The engine works in steps. In each step it picks the lowest-numbered pending lane as the leader and requests the 64-byte line that holds the leader's element. When the line comes back, the engine fills every pending lane whose element lies in that line and clears those mask bits. Steps repeat until no mask bit is set, and then `done` pulses for one cycle. The number of steps therefore equals the number of distinct lines that the pending lanes touch. Lanes that are masked off at the start keep the destination value supplied with the command.

Top module: `gather_engine`

## Requirements
- R1: After reset, `req_valid`, `done` and `busy` are low, and `mask_out`, `step_count` and `dest_out` are zero.
- R2: A lane's element address is `base_addr + 4*offset`, taken modulo 2^32. Lane k's offset is `lane_offsets[32k+31:32k]`.
- R3: While `req_valid` is high, `req_line_addr` equals the element address of the lowest-numbered lane whose mask bit is set, with its low 6 bits cleared.
- R4: When `resp_valid` arrives, every pending lane whose address lies in the requested line takes line word `addr[5:2]` into its `dest_out` lane and clears its mask bit. Line word w is `resp_line[32w+31:32w]`, and dest lane k is `dest_out[32k+31:32k]`.
- R5: Pending lanes whose address lies in another line keep their mask bit set and their destination unchanged.
- R6: A lane whose `mask_in` bit is zero at start keeps its `dest_in` value for the whole operation and is never the leader.
- R7: `done` is high for exactly one cycle. It is high in the cycle after the response that clears the last mask bit, and `mask_out` is zero at that time.
- R8: If `mask_in` is zero at start, `done` is high in the next cycle and no request is issued.
- R9: Once raised, `req_valid` stays high with a stable `req_line_addr` until `req_ready` is sampled high.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: `step_count` counts completed steps from zero at start. At `done` it equals the number of distinct lines touched by the pending lanes, which is 16 when all 16 lanes fall in different lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch a gather when idle |
| base_addr | input | 32 | Scalar base byte address |
| lane_offsets | input | 512 | Sixteen 32-bit element offsets |
| mask_in | input | 16 | Initial pending-lane mask |
| dest_in | input | 512 | Prior destination vector |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_line_addr | output | 32 | Line-aligned request address |
| resp_valid | input | 1 | Line data strobe |
| resp_line | input | 512 | Returned 64-byte line |
| dest_out | output | 512 | Destination vector being built |
| mask_out | output | 16 | Current pending mask |
| step_count | output | 5 | Steps completed so far |
| busy | output | 1 | Gather in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a `start` that arrives in the middle of a long gather while the memory stalls the request. The stimulus launches a 16-line gather, holds `req_ready` low for some cycles, and pulses `start` with a different base and mask at that moment. A behavioural model checked on every clock then shows that the latched command was not disturbed. A second hard case is a base address that is not line-aligned or that wraps at 2^32. Those patterns split consecutive offsets across two lines, or send lanes around the top of the address space.

// File: rtl/gather_engine.sv
module gather_engine #(
  parameter int LANES      = 16,
  parameter int ELEM_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [ADDR_W-1:0]         base_addr,
  input  logic [LANES*OFF_W-1:0]    lane_offsets,
  input  logic [LANES-1:0]          mask_in,
  input  logic [LANES*ELEM_W-1:0]   dest_in,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [ADDR_W-1:0]         req_line_addr,
  input  logic                      resp_valid,
  input  logic [LINE_BYTES*8-1:0]   resp_line,
  output logic [LANES*ELEM_W-1:0]   dest_out,
  output logic [LANES-1:0]          mask_out,
  output logic [$clog2(LANES+1)-1:0] step_count,
  output logic                      busy,
  output logic                      done
);
  localparam int ESZ_BITS = $clog2(ELEM_W/8);
  localparam int OFS_BITS = $clog2(LINE_BYTES);
  localparam int WSEL_W   = OFS_BITS - ESZ_BITS;
  localparam int TAG_W    = ADDR_W - OFS_BITS;
  localparam int LEAD_W   = $clog2(LANES);
  localparam int CNT_W    = $clog2(LANES+1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t                   state_q;
  logic [ADDR_W-1:0]        base_q;
  logic [LANES*OFF_W-1:0]   offs_q;
  logic [LANES-1:0]         mask_q;
  logic [CNT_W-1:0]         step_q;
  logic                     done_q;
  logic [ELEM_W-1:0]        dest_q   [LANES];
  logic [ADDR_W-1:0]        lane_addr[LANES];
  logic [TAG_W-1:0]         lane_tag [LANES];
  logic [WSEL_W-1:0]        word_sel [LANES];
  logic [LANES-1:0]         hit;
  logic [LEAD_W-1:0]        lead_idx;
  logic [LANES-1:0]         mask_left;
  logic                     take_resp;

  always_comb begin
    lead_idx = '0;
    for (int i = LANES-1; i >= 0; i--)
      if (mask_q[i]) lead_idx = LEAD_W'(i);
  end

  assign take_resp = (state_q == S_WAIT) && resp_valid;
  assign mask_left = mask_q & ~hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_addr[g] = base_q + (ADDR_W'(offs_q[g*OFF_W +: OFF_W]) << ESZ_BITS);
    assign lane_tag[g]  = lane_addr[g][ADDR_W-1:OFS_BITS];
    assign word_sel[g]  = lane_addr[g][OFS_BITS-1:ESZ_BITS];
    assign hit[g]       = mask_q[g] && (lane_tag[g] == lane_tag[lead_idx]);
    assign dest_out[g*ELEM_W +: ELEM_W] = dest_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dest_q[g] <= '0;
      else if (state_q == S_IDLE && start)
        dest_q[g] <= dest_in[g*ELEM_W +: ELEM_W];
      else if (take_resp && hit[g])
        dest_q[g] <= resp_line[int'(word_sel[g])*ELEM_W +: ELEM_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      offs_q  <= '0;
      mask_q  <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          base_q <= base_addr;
          offs_q <= lane_offsets;
          mask_q <= mask_in;
          step_q <= '0;
          if (mask_in == '0) done_q <= 1'b1;
          else               state_q <= S_REQ;
        end
        S_REQ: if (req_ready) state_q <= S_WAIT;
        S_WAIT: if (resp_valid) begin
          mask_q <= mask_left;
          step_q <= step_q + 1'b1;
          if (mask_left == '0) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_REQ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_valid     = (state_q == S_REQ);
  assign req_line_addr = {lane_tag[lead_idx], {OFS_BITS{1'b0}}};
  assign mask_out      = mask_q;
  assign step_count    = step_q;
  assign busy          = (state_q != S_IDLE);
  assign done          = done_q;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_line_addr)));

  assert_step_progress_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_resp |=> (((mask_q & ~$past(mask_q)) == '0) && (mask_q != $past(mask_q))));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mask_out == '0));

  assert_empty_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && mask_in == '0) |=> (done && !req_valid));

  assert_step_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    step_count <= CNT_W'(LANES));
endmodule

// File: tb/gather_engine_test.sv
module gather_engine_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] base_addr = 0;
  logic [511:0] lane_offsets = 0, dest_in = 0, resp_line = 0, dest_out;
  logic [15:0] mask_in = 0, mask_out;
  logic req_valid, req_ready = 0, resp_valid = 0, busy, done;
  logic [31:0] req_line_addr;
  logic [4:0] step_count;

  gather_engine uut (.clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .lane_offsets(lane_offsets), .mask_in(mask_in), .dest_in(dest_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_line_addr(req_line_addr),
    .resp_valid(resp_valid), .resp_line(resp_line), .dest_out(dest_out),
    .mask_out(mask_out), .step_count(step_count), .busy(busy), .done(done));

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0, handshakes = 0;
  bit live = 0, rand_ready = 0, mem_pend = 0;
  int mem_wait = 0;
  logic [31:0] mem_line = 0;
  logic [31:0] cur_off [16];

  int m_phase = 0;
  logic [15:0] m_mask = 0, m_orig = 0;
  logic [31:0] m_base = 0;
  logic [31:0] m_off [16];
  logic [31:0] m_dest [16];
  int m_step = 0;
  bit m_done = 0;

  function automatic logic [31:0] memword(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h1234_5678;
  endfunction

  function automatic logic [31:0] laddr(input logic [31:0] b, input logic [31:0] o);
    return b + (o << 2);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial for (int i = 0; i < 16; i++) begin
    m_off[i] = 0; m_dest[i] = 0; cur_off[i] = 0;
  end

  // behavioural reference, advanced on each rising edge from the inputs only
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_mask = 0; m_step = 0; m_done = 0;
      for (int i = 0; i < 16; i++) m_dest[i] = 0;
    end else begin
      bit nd;
      nd = 0;
      if (m_phase == 0) begin
        if (start) begin
          m_base = base_addr; m_mask = mask_in; m_orig = mask_in; m_step = 0;
          for (int i = 0; i < 16; i++) begin
            m_off[i] = lane_offsets[32*i +: 32];
            m_dest[i] = dest_in[32*i +: 32];
          end
          if (mask_in == 0) nd = 1; else m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (req_ready) m_phase = 2;
      end else if (resp_valid) begin
        int lead;
        logic [31:0] ln;
        lead = -1;
        for (int i = 15; i >= 0; i--) if (m_mask[i]) lead = i;
        ln = laddr(m_base, m_off[lead]) >> 6;
        for (int i = 0; i < 16; i++) begin
          logic [31:0] a;
          a = laddr(m_base, m_off[i]);
          if (m_mask[i] && (a >> 6) == ln) begin
            m_dest[i] = resp_line[32*int'(a[5:2]) +: 32];
            m_mask[i] = 0;
          end
        end
        m_step++;
        if (m_mask == 0) begin nd = 1; m_phase = 0; end else m_phase = 1;
      end
      m_done = nd;
    end
  end

  function automatic logic [31:0] exp_line();
    for (int i = 0; i < 16; i++)
      if (m_mask[i]) return laddr(m_base, m_off[i]) & ~32'h3F;
    return 0;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) if (live) begin
    chk(req_valid == (m_phase == 1), "R9 req_valid", req_valid, m_phase == 1);
    if (m_phase == 1) chk(req_line_addr == exp_line(), "R3 line address", req_line_addr, exp_line());
    chk(done == m_done, "R7 done", done, m_done);
    chk(mask_out == m_mask, "R5 mask", mask_out, m_mask);
    chk(step_count == m_step[4:0], "R11 step count", step_count, m_step);
    chk(busy == (m_phase != 0), "R10 busy", busy, m_phase != 0);
    for (int i = 0; i < 16; i++)
      chk(dest_out[32*i +: 32] == m_dest[i], m_orig[i] ? "R4 dest lane" : "R6 dest lane",
          dest_out[32*i +: 32], m_dest[i]);
  end

  // memory side
  always @(negedge clk) begin
    resp_valid = 0;
    if (mem_pend) begin
      if (mem_wait == 0) begin
        resp_valid = 1;
        for (int w = 0; w < 16; w++) resp_line[32*w +: 32] = memword(mem_line + 32'(4*w));
        mem_pend = 0;
      end else mem_wait--;
    end
    req_ready = rand_ready ? ($urandom % 3 == 0) : 1'b1;
    if (req_valid && req_ready && !mem_pend) begin
      mem_pend = 1; mem_line = req_line_addr; mem_wait = $urandom % 3; handshakes++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  function automatic int distinct_lines(input logic [31:0] b, input logic [15:0] m);
    int n = 0;
    for (int i = 0; i < 16; i++) if (m[i]) begin
      bit seen = 0;
      for (int j = 0; j < i; j++)
        if (m[j] && (laddr(b, cur_off[j]) >> 6) == (laddr(b, cur_off[i]) >> 6)) seen = 1;
      if (!seen) n++;
    end
    return n;
  endfunction

  task automatic run(input logic [31:0] b, input logic [15:0] m, input bit inject);
    int exp_steps, t;
    exp_steps = distinct_lines(b, m);
    @(negedge clk);
    base_addr = b; mask_in = m;
    for (int i = 0; i < 16; i++) begin
      lane_offsets[32*i +: 32] = cur_off[i];
      dest_in[32*i +: 32] = $urandom;
    end
    handshakes = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    if (m == 0) chk(done === 1'b1, "R8 done next cycle", done, 1);
    t = 0;
    while (!done && t < 3000) begin
      if (inject && t == 2) begin
        start = 1; base_addr = b ^ 32'h0000_4000; mask_in = 16'h0001;
      end else start = 0;
      @(negedge clk);
      t++;
    end
    start = 0;
    chk(done === 1'b1, "R7 completion", done, 1);
    chk(handshakes == exp_steps, m == 0 ? "R8 request count" : "R11 request count", handshakes, exp_steps);
    chk(step_count == 5'(exp_steps), "R11 final steps", step_count, exp_steps);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_valid == 0 && done == 0 && busy == 0, "R1 reset controls", {req_valid, done, busy}, 0);
    chk(mask_out == 0 && step_count == 0, "R1 reset counters", {mask_out, step_count}, 0);
    chk(dest_out == 0, "R1 reset dest", dest_out[63:0], 0);
    rst_n = 1;
    @(negedge clk);
    live = 1;

    // R4: all lanes share one address
    for (int i = 0; i < 16; i++) cur_off[i] = 7;
    run(32'h0000_1000, 16'hFFFF, 0);
    // R4: consecutive elements in one aligned line
    for (int i = 0; i < 16; i++) cur_off[i] = i;
    run(32'h0000_2000, 16'hFFFF, 0);
    // R5: unaligned base splits into two lines
    run(32'h0000_3008, 16'hFFFF, 0);
    // R11: every lane in its own line
    for (int i = 0; i < 16; i++) cur_off[i] = 16 * (15 - i);
    run(32'h0001_0000, 16'hFFFF, 0);
    // R6: partial mask
    run(32'h0002_0000, 16'hA5A5, 0);
    // R8: empty mask
    run(32'h0003_0000, 16'h0000, 0);
    // R2: wrap around the top of the address space
    for (int i = 0; i < 16; i++) cur_off[i] = 3 * i;
    run(32'hFFFF_FFE0, 16'hFFFF, 0);
    // R10: start while busy, with a stalling memory
    rand_ready = 1;
    for (int i = 0; i < 16; i++) cur_off[i] = 16 * i + 1;
    run(32'h0004_0000, 16'hFFFF, 1);
    // R3/R4: clustered random indices, random stalls
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 16; i++) cur_off[i] = $urandom % 48;
      run($urandom & 32'hFFFF_FFFC, 16'($urandom), 0);
    end
    live = 0;
    summary();
  end
endmodule